// File: doc/BRIEF.md
# DRAM Cycle Decoder with Parallel Test Mode

This block is a synthesizable device-side model of the control logic of an asynchronous-strobe DRAM with extended-data-out page mode. A fast system clock samples the active-low row strobe, column strobe, write enable and output enable. The block infers the kind of each memory cycle from the order in which the strobes move, and a small internal array stands in for the cell matrix. When the row strobe falls, the state of the column strobe and write enable picks one of three paths: an addressed row open, a refresh that takes its row from an internal counter, or a refresh that also arms a latched test mode.

Inside an addressed row, each column-strobe fall starts a read or an early write. A write-enable fall after a read turns that access into a read-modify-write. Read data stays on the output after the column strobe rises, as extended-data-out operation requires. In test mode, a read returns a bitwise equality compare between two internal cells that differ only in the top column bit. At each row-strobe rise the block pulses a one-clock report carrying the cycle class, so that a bench or a bus monitor can follow the traffic.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, `dq_oe_o`, `cyc_valid_o` and `test_mode_o` are 0 and the refresh counter holds 0.
- R2: When `ras_ni` falls while `cas_ni` is high, `addr_i` is latched and shown on `row_o`. A cycle with no column access is reported as row-only refresh, type code 4.
- R3: When `ras_ni` falls while `cas_ni` is low, `row_o` shows the refresh counter. The counter then advances by one and wraps from 2047 to 0. With `we_ni` high at that fall the cycle is reported as type 5.
- R4: When `ras_ni` falls while both `cas_ni` and `we_ni` are low, the cycle is reported as type 6. `test_mode_o` rises at the report and stays set through later read and write cycles.
- R5: Test mode clears at the report of a type 4 or type 5 cycle.
- R6: A `cas_ni` fall with `we_ni` high inside an addressed row is a read. `dq_o` shows the cell at row `row_o[3:0]`, column `addr_i[3:0]`, and the cycle is reported as type 1.
- R7: A `cas_ni` fall with `we_ni` low is an early write. It stores `dq_i` at that column, `dq_oe_o` stays 0 for the access, and the cycle is reported as type 2.
- R8: A `we_ni` fall while `cas_ni` is still low after a read stores `dq_i` at the read column and turns the output off. The cycle is reported as type 3.
- R9: Read data stays driven after `cas_ni` rises. The output turns off when `ras_ni` and `cas_ni` are both high, or when `we_ni` falls. It is masked while `oe_ni` is high. A refresh that starts with `cas_ni` still low keeps the data driven.
- R10: In test mode, bit i of a read returns 1 when bit i of cell (row, col) equals bit i of cell (row, col with bit 3 inverted), and 0 otherwise.
- R11: `cyc_valid_o` is high for exactly one clock after each `ras_ni` rise, with `cyc_type_o` valid in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 11 | Multiplexed row/column address |
| dq_i | input | 8 | Write data |
| dq_o | output | 8 | Read data or test compare result |
| dq_oe_o | output | 1 | Data output drive enable |
| cyc_valid_o | output | 1 | One-clock cycle report strobe |
| cyc_type_o | output | 3 | Cycle class: 1 read, 2 early write, 3 read-modify-write, 4 row-only refresh, 5 refresh, 6 test entry |
| row_o | output | 11 | Row of the current cycle |
| test_mode_o | output | 1 | Test mode latched |

## Verification
Every result is registered at the clock edge that first samples the strobe change. `row_o`, read data, output enable, test mode and the cycle report are therefore all due exactly one edge after the stimulus, and the OE mask follows its own register by the same single edge. The bench changes inputs just after a falling clock edge and compares at the next falling edge, so each check lands in the cycle its result is due. Sweeps fill and read back every cell of a 16x16 array, read every column in test mode against compare values computed from a scoreboard, and run the refresh counter through its wrap.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic [2:0] {
    CYC_NONE = 3'd0,
    CYC_READ = 3'd1,
    CYC_EWR  = 3'd2,
    CYC_RMW  = 3'd3,
    CYC_ROR  = 3'd4,
    CYC_CBR  = 3'd5,
    CYC_TEST = 3'd6
  } cyc_e;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_READ,
    ACC_WRITE,
    ACC_RMW
  } acc_e;
endpackage

// File: rtl/dcd_strobe_edge.sv
module dcd_strobe_edge #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] strb_ni,
  output logic [N-1:0] strb_q_o,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strb_q_o <= '1;
    else         strb_q_o <= strb_ni;
  end

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign fall_o[g] = strb_q_o[g] & ~strb_ni[g];
    assign rise_o[g] = ~strb_q_o[g] & strb_ni[g];
  end
endmodule

// File: rtl/dcd_refresh_ctr.sv
module dcd_refresh_ctr #(
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + W'(1);
  end

  AST_CTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_o)); // R3
endmodule

// File: rtl/dcd_store.sv
module dcd_store #(
  parameter int DEPTH = 256,
  parameter int DW    = 8
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_a_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_b_i,
  output logic [DW-1:0]            rdata_a_o,
  output logic [DW-1:0]            rdata_b_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem[raddr_a_i];
  assign rdata_b_o = mem[raddr_b_i];
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dcd_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DW     = 8,
  parameter int ROWS   = 16,
  parameter int COLS   = 16,
  parameter int REF_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     dq_i,
  output logic [DW-1:0]     dq_o,
  output logic              dq_oe_o,
  output logic              cyc_valid_o,
  output logic [2:0]        cyc_type_o,
  output logic [ADDR_W-1:0] row_o,
  output logic              test_mode_o
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam int DEPTH = ROWS * COLS;
  localparam int AW    = ROW_W + COL_W;
  localparam int I_RAS = 0;
  localparam int I_CAS = 1;
  localparam int I_WE  = 2;
  localparam int I_OE  = 3;
  localparam logic [COL_W-1:0] COL_MSB = COL_W'(1) << (COL_W - 1);

  logic [3:0] strb_q, fall, rise;
  logic       ras_fall, ras_rise, cas_fall, we_fall;
  logic       unused_edges;

  dcd_strobe_edge #(.N(4)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strb_ni  ({oe_ni, we_ni, cas_ni, ras_ni}),
    .strb_q_o (strb_q),
    .fall_o   (fall),
    .rise_o   (rise)
  );

  assign ras_fall     = fall[I_RAS];
  assign ras_rise     = rise[I_RAS];
  assign cas_fall     = fall[I_CAS];
  assign we_fall      = fall[I_WE];
  assign unused_edges = ^{rise[3:1], fall[I_OE]};

  logic              ras_act, refr_q, wcbr_q, out_valid, test_q, valid_q;
  logic [ADDR_W-1:0] row_q;
  logic [COL_W-1:0]  col_q;
  logic [DW-1:0]     dout_q;
  acc_e              acc_q;
  cyc_e              type_q, rep_type;
  logic [REF_W-1:0]  ref_cnt;

  // Column access and read-modify-write events inside an addressed row
  logic acc_cas, rmw_ev;
  assign acc_cas = cas_fall & ras_act & ~ras_ni & ~refr_q;
  assign rmw_ev  = we_fall & ras_act & ~ras_ni & ~cas_ni & ~refr_q
                 & (acc_q == ACC_READ) & ~acc_cas;

  dcd_refresh_ctr #(.W(REF_W)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (ras_fall & ~cas_ni),
    .cnt_o  (ref_cnt)
  );

  logic [COL_W-1:0] col_a;
  logic [AW-1:0]    waddr, raddr_a, raddr_b;
  logic [DW-1:0]    rd_a, rd_b;
  logic             st_we;

  assign col_a   = addr_i[COL_W-1:0];
  assign raddr_a = {row_q[ROW_W-1:0], col_a};
  assign raddr_b = {row_q[ROW_W-1:0], col_a ^ COL_MSB};
  assign waddr   = acc_cas ? raddr_a : {row_q[ROW_W-1:0], col_q};
  assign st_we   = (acc_cas & ~we_ni) | rmw_ev;

  dcd_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i     (clk_i),
    .we_i      (st_we),
    .waddr_i   (waddr),
    .wdata_i   (dq_i),
    .raddr_a_i (raddr_a),
    .raddr_b_i (raddr_b),
    .rdata_a_o (rd_a),
    .rdata_b_o (rd_b)
  );

  always_comb begin
    if (refr_q) rep_type = wcbr_q ? CYC_TEST : CYC_CBR;
    else begin
      unique case (acc_q)
        ACC_READ:  rep_type = CYC_READ;
        ACC_WRITE: rep_type = CYC_EWR;
        ACC_RMW:   rep_type = CYC_RMW;
        default:   rep_type = CYC_ROR;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_act   <= 1'b0;
      refr_q    <= 1'b0;
      wcbr_q    <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      acc_q     <= ACC_NONE;
      out_valid <= 1'b0;
      dout_q    <= '0;
      test_q    <= 1'b0;
      valid_q   <= 1'b0;
      type_q    <= CYC_NONE;
    end else begin
      valid_q <= 1'b0;
      if (ras_fall) begin
        ras_act <= 1'b1;
        refr_q  <= ~cas_ni;
        wcbr_q  <= ~cas_ni & ~we_ni;
        row_q   <= cas_ni ? addr_i : ADDR_W'(ref_cnt);
        acc_q   <= ACC_NONE;
      end else if (ras_rise) begin
        ras_act <= 1'b0;
        valid_q <= 1'b1;
        type_q  <= rep_type;
        if (rep_type == CYC_TEST) test_q <= 1'b1;
        else if (rep_type == CYC_ROR || rep_type == CYC_CBR) test_q <= 1'b0;
      end
      if (acc_cas) begin
        col_q <= col_a;
        acc_q <= we_ni ? ACC_READ : ACC_WRITE;
      end else if (rmw_ev) begin
        acc_q <= ACC_RMW;
      end
      // Extended-data-out: data held until both strobes high or WE falls
      if (acc_cas) begin
        out_valid <= we_ni;
        if (we_ni) dout_q <= test_q ? ~(rd_a ^ rd_b) : rd_a;
      end else if (we_fall || (ras_ni && cas_ni)) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign dq_o        = dout_q;
  assign dq_oe_o     = out_valid & ~strb_q[I_OE];
  assign cyc_valid_o = valid_q;
  assign cyc_type_o  = type_q;
  assign row_o       = row_q;
  assign test_mode_o = test_q;

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o |=> !cyc_valid_o); // R11
  AST_VALID_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o |-> (strb_q[I_RAS] && !$past(strb_q[I_RAS]))); // R11
  AST_EWR_DQ_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_fall && ras_act && !ras_ni && !refr_q && !we_ni) |=> !dq_oe_o); // R7
  AST_WE_FALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_fall |=> !dq_oe_o); // R9
  AST_TM_AT_REPORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(test_mode_o) |-> cyc_valid_o); // R4
endmodule

// File: tb/tb_dram_cycle_decoder.sv
module tb_dram_cycle_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras = 1'b1, cas = 1'b1, we = 1'b1, oe = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dq_o;
  logic        dq_oe_o, cyc_valid_o, test_mode_o;
  logic [2:0]  cyc_type_o;
  logic [10:0] row_o;

  int n_chk = 0, n_fail = 0, exp_cnt = 0;
  bit done = 1'b0;
  logic [7:0] sb [16][16];

  always #2 clk = ~clk;

  dram_cycle_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras), .cas_ni(cas), .we_ni(we),
    .oe_ni(oe), .addr_i(addr), .dq_i(din), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
    .cyc_valid_o(cyc_valid_o), .cyc_type_o(cyc_type_o), .row_o(row_o),
    .test_mode_o(test_mode_o)
  );

  task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int r, input int c);
    return 8'(((r * 37) + (c * 11)) ^ 8'hC3);
  endfunction

  function automatic logic [10:0] row_addr(input int r);
    return 11'h150 | 11'(r);
  endfunction

  task automatic ras_open(input logic [10:0] a);
    addr = a;
    ras = 1'b0;
    step();
    chk(row_o == a, "R2 row latched", row_o, a);
  endtask

  task automatic ras_close(input int exp_type, input string tag);
    ras = 1'b1;
    step();
    chk(cyc_valid_o && cyc_type_o == 3'(exp_type), tag, {cyc_valid_o, cyc_type_o}, 8 + exp_type);
    step();
    chk(!cyc_valid_o, "R11 report single pulse", cyc_valid_o, 0);
  endtask

  task automatic page_read(input int c, input logic [7:0] e, input string tag);
    we = 1'b1;
    addr = 11'(c);
    cas = 1'b0;
    step();
    chk(dq_oe_o && dq_o == e, tag, {dq_oe_o, dq_o}, {1'b1, e});
    cas = 1'b1;
    step();
    chk(dq_oe_o && dq_o == e, "R9 EDO hold after CAS rise", {dq_oe_o, dq_o}, {1'b1, e});
  endtask

  task automatic page_write(input int c, input logic [7:0] d);
    we = 1'b0;
    din = d;
    addr = 11'(c);
    cas = 1'b0;
    step();
    chk(!dq_oe_o, "R7 early write DQ off", dq_oe_o, 0);
    cas = 1'b1;
    we = 1'b1;
    step();
    chk(!dq_oe_o, "R7 early write DQ off after CAS", dq_oe_o, 0);
  endtask

  task automatic cbr(input bit wlow, input int exp_type);
    cas = 1'b0;
    we = ~wlow;
    step();
    ras = 1'b0;
    step();
    chk(row_o == 11'(exp_cnt), "R3 refresh row from counter", row_o, exp_cnt);
    exp_cnt = (exp_cnt + 1) % 2048;
    we = 1'b1;
    ras = 1'b1;
    step();
    chk(cyc_valid_o && cyc_type_o == 3'(exp_type), wlow ? "R4 test entry type" : "R3 refresh type",
        cyc_type_o, exp_type);
    cas = 1'b1;
    step();
    chk(!cyc_valid_o, "R11 report single pulse", cyc_valid_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk(!dq_oe_o && !cyc_valid_o && !test_mode_o, "R1 reset outputs",
        {dq_oe_o, cyc_valid_o, test_mode_o}, 0);

    // R1 R3: first refresh uses counter value 0
    cbr(1'b0, 5);

    // Fill every cell with early writes, page mode per row
    for (int r = 0; r < 16; r++) begin
      ras_open(row_addr(r));
      for (int c = 0; c < 16; c++) begin
        page_write(c, pat(r, c));
        sb[r][c] = pat(r, c);
      end
      ras_close(2, "R7 early write type");
    end

    // R6: read back all cells
    for (int r = 0; r < 16; r++) begin
      ras_open(row_addr(r));
      for (int c = 0; c < 16; c++) page_read(c, sb[r][c], "R6 read data");
      ras_close(1, "R6 read type");
      chk(!dq_oe_o, "R9 off when RAS and CAS high", dq_oe_o, 0);
    end

    // R9: OE mask
    ras_open(row_addr(2));
    we = 1'b1; addr = 11'd4; cas = 1'b0;
    step();
    chk(dq_oe_o, "R6 drive with OE low", dq_oe_o, 1);
    oe = 1'b1;
    step();
    chk(!dq_oe_o, "R9 OE high masks output", dq_oe_o, 0);
    oe = 1'b0;
    step();
    chk(dq_oe_o && dq_o == sb[2][4], "R9 OE low restores data", dq_o, sb[2][4]);
    cas = 1'b1;
    step();
    ras_close(1, "R6 read type");

    // R9: WE pulse turns EDO output off
    ras_open(row_addr(2));
    page_read(1, sb[2][1], "R6 read data");
    we = 1'b0;
    step();
    chk(!dq_oe_o, "R9 WE pulse turns off output", dq_oe_o, 0);
    we = 1'b1;
    step();
    ras_close(1, "R6 read type after WE pulse");

    // R8: read-modify-write
    ras_open(row_addr(3));
    we = 1'b1; addr = 11'd9; cas = 1'b0;
    step();
    chk(dq_oe_o && dq_o == sb[3][9], "R8 RMW read phase", dq_o, sb[3][9]);
    din = 8'hA5; we = 1'b0;
    step();
    chk(!dq_oe_o, "R8 RMW output off after WE", dq_oe_o, 0);
    cas = 1'b1; we = 1'b1;
    step();
    sb[3][9] = 8'hA5;
    ras_close(3, "R8 RMW type");
    ras_open(row_addr(3));
    page_read(9, 8'hA5, "R8 RMW data stored");
    page_read(8, sb[3][8], "R8 neighbour untouched");
    ras_close(1, "R6 read type");

    // R2: row-only refresh
    ras_open(11'h7FF);
    ras_close(4, "R2 row-only refresh type");

    // R4 R10: test mode entry and compare reads
    cbr(1'b1, 6);
    chk(test_mode_o, "R4 test mode set", test_mode_o, 1);
    ras_open(row_addr(7));
    for (int c = 0; c < 16; c++)
      page_read(c, ~(sb[7][c] ^ sb[7][c ^ 8]), "R10 test compare");
    ras_close(1, "R6 read type in test mode");
    chk(test_mode_o, "R4 test mode held", test_mode_o, 1);
    ras_open(row_addr(5));
    page_write(2, 8'h3C);
    page_write(10, 8'h3C);
    sb[5][2] = 8'h3C;
    sb[5][10] = 8'h3C;
    page_read(2, 8'hFF, "R10 equal pair reads all ones");
    page_read(3, ~(sb[5][3] ^ sb[5][11]), "R10 test compare");
    ras_close(1, "R6 read type in test mode");
    chk(test_mode_o, "R4 test mode held after write", test_mode_o, 1);

    // R5: exits
    ras_open(row_addr(0));
    ras_close(4, "R2 row-only refresh type");
    chk(!test_mode_o, "R5 row-only refresh clears test mode", test_mode_o, 0);
    ras_open(row_addr(5));
    page_read(2, 8'h3C, "R5 normal read after exit");
    ras_close(1, "R6 read type");
    cbr(1'b1, 6);
    chk(test_mode_o, "R4 test mode re-entered", test_mode_o, 1);
    cbr(1'b0, 5);
    chk(!test_mode_o, "R5 refresh clears test mode", test_mode_o, 0);

    // R9: hidden refresh keeps data
    ras_open(row_addr(9));
    we = 1'b1; addr = 11'd6; cas = 1'b0;
    step();
    chk(dq_oe_o && dq_o == sb[9][6], "R6 read data", dq_o, sb[9][6]);
    ras = 1'b1;
    step();
    chk(cyc_valid_o && cyc_type_o == 3'd1, "R11 read report", cyc_type_o, 1);
    chk(dq_oe_o && dq_o == sb[9][6], "R9 data held with CAS low", dq_o, sb[9][6]);
    ras = 1'b0;
    step();
    chk(row_o == 11'(exp_cnt), "R3 hidden refresh row", row_o, exp_cnt);
    chk(dq_oe_o && dq_o == sb[9][6], "R9 hidden refresh keeps data", dq_o, sb[9][6]);
    exp_cnt = (exp_cnt + 1) % 2048;
    ras = 1'b1;
    step();
    chk(cyc_valid_o && cyc_type_o == 3'd5, "R3 hidden refresh type", cyc_type_o, 5);
    cas = 1'b1;
    step();
    chk(!dq_oe_o, "R9 off when both strobes high", dq_oe_o, 0);

    // R3: counter through wrap
    for (int i = 0; i < 2050; i++) cbr(1'b0, 5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule